// File: doc/BRIEF.md
# Strided and Paged Memory Address Sequencer

This block supplies the data-memory address stream for one read or write switch of a vector datapath while a streamed kernel runs. One instance serves each switch. Software sets the configuration inputs, then pulses `start`. From then on, each cycle in which data moves, `step` advances the address to the next element. Memory banks and switch multiplexing lie outside the block.

Two walking patterns are available. The linear pattern adds a fixed stride for each element, which suits filter taps and branch-metric reads. The paged pattern adds an in-page stride for a programmed number of elements. On the first element of each new page it instead jumps to the previous page's first address plus a page displacement, which suits butterfly and survivor-metric writes. For element n with page length P, the address is base + floor(n/P)·page_disp + (n mod P)·elem_disp, modulo the address space. The block builds this with adders and counters only, without a multiplier. A done flag marks the final element of a stream of programmed length.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `addr` is 0 and `done` is 1, and `step` pulses before the first `start` leave `addr` at 0.
- R2: The cycle after `start` is sampled high, `addr` equals the `base_addr` that was sampled with it.
- R3: When `mode_paged` was 0 at the last start, each accepted step adds the element stride to `addr`.
- R4: When `mode_paged` was 1 at the last start, a step within a page adds the element stride.
- R5: In paged mode, the step that completes `page_len` elements moves `addr` to the first address of the page just finished plus `page_disp`.
- R6: `done` is 1 exactly when `addr` holds the address of element `total_len`-1, counting the first as element 0. A `total_len` of 0 is treated as 1.
- R7: While `done` is 1, `step` is ignored and `addr` holds.
- R8: A cycle without `step` or `start` leaves `addr` unchanged.
- R9: Address arithmetic wraps modulo 2^ADDR_W (4096 by default).
- R10: `start` takes priority over `step` in the same cycle and restarts a stream in progress.
- R11: The block samples `mode_paged`, `elem_disp`, `page_disp`, `page_len` and `total_len` only at `start`. Changes made later do not alter the stream.
- R12: A `page_len` of 0 behaves as 1, so every step applies `page_disp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads the base address and configuration and clears the counters |
| step | input | 1 | Advances to the next element |
| mode_paged | input | 1 | 1 selects the paged pattern, 0 the linear pattern |
| base_addr | input | ADDR_W | Address of element 0 |
| elem_disp | input | ADDR_W | Stride between adjacent elements (within a page in paged mode) |
| page_disp | input | ADDR_W | Displacement from one page start to the next |
| page_len | input | PAGE_W | Elements per page |
| total_len | input | CNT_W | Elements in the stream |
| addr | output | ADDR_W | Current element address |
| done | output | 1 | Final element reached |

## Verification
On every cycle, the assertions check the following: the address holds when no step is accepted, the address is reloaded from the base after a start, the linear stride is added on each accepted step, and `done` can only rise after a start or a step. Other behaviours need the bench's scenarios because they depend on a whole stream: the page jump after exactly `page_len` elements, the element on which `done` rises, wrap-around at the top of the address space, the degenerate page and stream lengths, and the configuration being held from `start` onward.

// File: rtl/agen_pkg.sv
package agen_pkg;
   typedef enum logic {
      WALK_LINEAR = 1'b0,
      WALK_PAGED  = 1'b1
   } walk_e;
endpackage

// File: rtl/agen_page.sv
// Position within the current page; flags the last element of a page.
module agen_page #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [PAGE_W-1:0] plen,
   output logic              last
);
   logic [PAGE_W-1:0] pos_q;
   logic [PAGE_W:0]   pos_inc;

   assign pos_inc = {1'b0, pos_q} + 1'b1;
   // A length of 0 compares like 1: every element closes its page.
   assign last    = pos_inc >= {1'b0, plen};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (clr)     pos_q <= '0;
      else if (adv)     pos_q <= last ? '0 : pos_inc[PAGE_W-1:0];
   end
endmodule

// File: rtl/agen_count.sv
// Element index and the final-element flag.
module agen_count #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] tot_at_clr,
   input  logic [CNT_W-1:0] tot_q,
   output logic             done
);
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] idx_nxt;
   logic [CNT_W-1:0] last_idx;

   assign idx_nxt  = idx_q + 1'b1;
   assign last_idx = (tot_q == '0) ? '0 : tot_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         done  <= 1'b1;
      end else if (clr) begin
         idx_q <= '0;
         done  <= (tot_at_clr <= CNT_W'(1));
      end else if (adv) begin
         idx_q <= idx_nxt;
         done  <= (idx_nxt == last_idx);
      end
   end
endmodule

// File: rtl/agen_addr.sv
// Address datapath: linear stride or page-relative stride plus page jump.
module agen_addr
   import agen_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  walk_e             walk,
   input  logic              page_last,
   input  logic [ADDR_W-1:0] elem_disp,
   input  logic [ADDR_W-1:0] page_disp,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] page_start_q;
   logic [ADDR_W-1:0] next_page;
   logic              jump;

   assign next_page = page_start_q + page_disp;
   assign jump      = (walk == WALK_PAGED) && page_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr         <= '0;
         page_start_q <= '0;
      end else if (clr) begin
         addr         <= base;
         page_start_q <= base;
      end else if (adv) begin
         if (jump) begin
            addr         <= next_page;
            page_start_q <= next_page;
         end else begin
            addr         <= addr + elem_disp;
         end
      end
   end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
   import agen_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 8,
   parameter int CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic              mode_paged,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] elem_disp,
   input  logic [ADDR_W-1:0] page_disp,
   input  logic [PAGE_W-1:0] page_len,
   input  logic [CNT_W-1:0]  total_len,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         initial $error("ADDR_W out of range");
      end
      if (PAGE_W < 1) begin : g_bad_page
         initial $error("PAGE_W must be positive");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         initial $error("CNT_W must be positive");
      end
   endgenerate

   walk_e             cfg_walk;
   logic [ADDR_W-1:0] cfg_elem;
   logic [ADDR_W-1:0] cfg_page;
   logic [PAGE_W-1:0] cfg_plen;
   logic [CNT_W-1:0]  cfg_tot;
   logic              adv;
   logic              page_last;

   assign adv = step && !done && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_walk <= WALK_LINEAR;
         cfg_elem <= '0;
         cfg_page <= '0;
         cfg_plen <= '0;
         cfg_tot  <= '0;
      end else if (start) begin
         cfg_walk <= walk_e'(mode_paged);
         cfg_elem <= elem_disp;
         cfg_page <= page_disp;
         cfg_plen <= page_len;
         cfg_tot  <= total_len;
      end
   end

   agen_page #(.PAGE_W(PAGE_W)) u_page (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv),
      .plen(cfg_plen), .last(page_last)
   );

   agen_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv),
      .tot_at_clr(total_len), .tot_q(cfg_tot), .done(done)
   );

   agen_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(start), .base(base_addr), .adv(adv),
      .walk(cfg_walk), .page_last(page_last), .elem_disp(cfg_elem),
      .page_disp(cfg_page), .addr(addr)
   );
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              step,
   input logic [ADDR_W-1:0] base_addr,
   input logic [ADDR_W-1:0] addr,
   input logic              done,
   input logic              lin_cfg,
   input logic [ADDR_W-1:0] stride_cfg
);
   assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> addr == $past(base_addr));

   assert_hold_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(addr));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !start) |=> $stable(addr));

   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && !done && lin_cfg) |=> addr == $past(addr) + $past(stride_cfg));

   assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(start) || $past(step)));
endmodule

bind stride_addr_gen agen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .step(step),
   .base_addr(base_addr), .addr(addr), .done(done),
   .lin_cfg(cfg_walk == agen_pkg::WALK_LINEAR), .stride_cfg(cfg_elem)
);

// File: tb/test_stride_addr_gen.sv
module test_stride_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 23;

   typedef struct packed {
      logic        st;
      logic        sp;
      logic        pg;
      logic [11:0] base;
      logic [11:0] ed;
      logic [11:0] pd;
      logic [7:0]  plen;
      logic [9:0]  tot;
      logic [11:0] ea;
      logic        edn;
   } vec_t;

   // start, step, paged, base, elem, page, plen, total, exp addr, exp done
   localparam vec_t VEC [NVEC] = '{
      '{1'b1,1'b0,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h100,1'b0}, // R2
      '{1'b0,1'b1,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h104,1'b0}, // R3
      '{1'b0,1'b0,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h104,1'b0}, // R8
      '{1'b0,1'b1,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h108,1'b0}, // R3
      '{1'b0,1'b1,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h10C,1'b1}, // R6
      '{1'b0,1'b1,1'b0,12'h100,12'h004,12'h000,8'd0,10'd4,12'h10C,1'b1}, // R7
      '{1'b1,1'b0,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h200,1'b0}, // R2
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h201,1'b0}, // R4
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h202,1'b0}, // R4
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h210,1'b0}, // R5
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h211,1'b0}, // R4
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h212,1'b0}, // R4
      '{1'b0,1'b1,1'b1,12'h200,12'h001,12'h010,8'd3,10'd7,12'h220,1'b1}, // R5 R6
      '{1'b1,1'b0,1'b0,12'hFFE,12'h003,12'h000,8'd0,10'd5,12'hFFE,1'b0}, // R2
      '{1'b0,1'b1,1'b0,12'hFFE,12'h003,12'h000,8'd0,10'd5,12'h001,1'b0}, // R9
      '{1'b1,1'b1,1'b0,12'h050,12'h002,12'h000,8'd0,10'd3,12'h050,1'b0}, // R10
      '{1'b0,1'b1,1'b0,12'h050,12'h002,12'h000,8'd0,10'd3,12'h052,1'b0}, // R3
      '{1'b0,1'b1,1'b1,12'h050,12'h007,12'h100,8'd1,10'd9,12'h054,1'b1}, // R11
      '{1'b1,1'b0,1'b1,12'h300,12'h005,12'h020,8'd0,10'd3,12'h300,1'b0}, // R2
      '{1'b0,1'b1,1'b1,12'h300,12'h005,12'h020,8'd0,10'd3,12'h320,1'b0}, // R12
      '{1'b0,1'b1,1'b1,12'h300,12'h005,12'h020,8'd0,10'd3,12'h340,1'b1}, // R12
      '{1'b1,1'b0,1'b0,12'h007,12'h001,12'h000,8'd0,10'd0,12'h007,1'b1}, // R6
      '{1'b0,1'b1,1'b0,12'h007,12'h001,12'h000,8'd0,10'd0,12'h007,1'b1}  // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, step = 1'b0, mode_paged = 1'b0;
   logic [11:0] base_addr = '0, elem_disp = '0, page_disp = '0;
   logic [7:0]  page_len = '0;
   logic [9:0]  total_len = '0;
   logic [11:0] addr;
   logic        done;
   int          n_run = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stride_addr_gen i_stride_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .mode_paged(mode_paged), .base_addr(base_addr), .elem_disp(elem_disp),
      .page_disp(page_disp), .page_len(page_len), .total_len(total_len),
      .addr(addr), .done(done)
   );

   task automatic check(input string req, input logic [11:0] ea, input logic edn);
      n_run++;
      if (addr !== ea || done !== edn) begin
         n_fail++;
         $display("FAIL %s: addr=%h done=%b expected addr=%h done=%b", req, addr, done, ea, edn);
      end
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state and steps before any start
      #(CLK_PERIOD*2 + 1);
      check("R1 in reset", 12'h000, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); check("R1 after reset", 12'h000, 1'b1);
      step = 1'b1;
      @(posedge clk); #1 check("R1 step ignored before start", 12'h000, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         start = VEC[i].st; step = VEC[i].sp; mode_paged = VEC[i].pg;
         base_addr = VEC[i].base; elem_disp = VEC[i].ed; page_disp = VEC[i].pd;
         page_len = VEC[i].plen; total_len = VEC[i].tot;
         @(posedge clk); #1;
         check($sformatf("vector %0d", i), VEC[i].ea, VEC[i].edn);
      end

      // R1: reset in the middle of a stream
      @(negedge clk);
      start = 1'b1; step = 1'b0; mode_paged = 1'b0; base_addr = 12'h0A0;
      elem_disp = 12'h001; total_len = 10'd8;
      @(negedge clk); start = 1'b0; step = 1'b1;
      @(negedge clk); check("R3 before mid reset", 12'h0A1, 1'b0);
      rst_n = 1'b0; step = 1'b0;
      #1 check("R1 mid-stream reset", 12'h000, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); check("R1 after mid reset", 12'h000, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule